// File: doc/BRIEF.md
# Latched-Operand Nibble Arithmetic Cluster

This block groups four 4-bit compute units behind one command port: two adder/subtractors, a multiplier and a bitwise logic unit. Each unit owns a private pair of operand registers (A and B). Operand A of any unit is always captured from the first input bus, and operand B from the second. The operands stay in place until they are loaded again, so a value loaded once can feed many operations.

A 4-bit command is taken when the strobe is high. Commands 0 to 7 write one operand register. Commands 8 to F fire one unit, and the 4-bit answer appears on a registered result bus together with a single-cycle valid flag. The adders add or subtract (two's complement) and drop any carry. The multiplier returns either half of its 8-bit product, chosen by a separate select input. The bitwise unit performs AND, XOR or OR.

Top module: `nibble_alu_cluster`

## Requirements
- R1: Synchronous active-high reset clears res_valid and res_data to 0 and sets every operand register to 0, so any run command issued straight after reset returns 0.
- R2: A strobed command with bit 3 clear loads one operand register. Bits 2:1 pick the unit (00 adder 0, 01 adder 1, 10 multiplier, 11 bitwise). Bit 0 = 0 loads operand A from bus_x, and bit 0 = 1 loads operand B from bus_y. A load command never raises res_valid.
- R3: Command 8 (adder 0) and command 9 (adder 1) return A + B modulo 16, with the carry discarded.
- R4: Command A (adder 0) and command B (adder 1) return A − B in 4-bit two's complement (bit 3 weighs −8), modulo 16.
- R5: Command C returns bits 3:0 of the 8-bit unsigned product A × B when mul_hi_sel is 0, and bits 7:4 when it is 1. The select is sampled together with the strobe.
- R6: Commands D, E and F return A AND B, A XOR B and A OR B of the bitwise unit.
- R7: For a strobed run command (8 to F), res_data takes the result and res_valid is 1 for exactly one cycle, both visible after the next rising edge. When no run occurs, res_data holds its last value.
- R8: An operand register keeps its value until a load command addresses it. Loading one register leaves the other registers of the same unit, and all registers of the other units, unchanged.
- R9: While cmd_valid is low, cmd_code, the buses and mul_hi_sel have no effect: no operand changes and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe that qualifies cmd_code |
| cmd_code | input | 4 | Load (0–7) or run (8–F) command |
| bus_x | input | 4 | Source for A operand loads |
| bus_y | input | 4 | Source for B operand loads |
| mul_hi_sel | input | 1 | Multiplier half select: 0 low nibble, 1 high nibble |
| res_data | output | 4 | Registered result bus |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The embedded properties assume that cmd_valid and cmd_code are never unknown after reset, and that a run command has exactly one unit to fire. They also assume that the result-hold property can treat any cycle without a strobed run as idle. The stimulus drives every input on the falling edge. It raises the strobe for a single cycle per command and then returns it low, so each load or run is seen at exactly one rising edge. Idle cycles are inserted between commands so that the pulse width and the hold behaviour can be checked.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

    localparam int NIB_W   = 4;
    localparam int N_UNITS = 4;
    localparam int N_ADD   = 2;
    localparam int PROD_W  = 2 * NIB_W;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t a;
        nib_t b;
    } operand_pair_t;

    typedef enum logic [1:0] {
        LOGIC_AND = 2'b01,
        LOGIC_XOR = 2'b10,
        LOGIC_OR  = 2'b11
    } logic_op_e;

    localparam logic [1:0] UNIT_MUL = 2'd2;
    localparam logic [1:0] UNIT_BIT = 2'd3;

    // Which unit a run command (bit 3 set) fires
    function automatic logic [1:0] run_target(input logic [3:0] code);
        logic [1:0] u;
        case (code[2:0])
            3'b000, 3'b010: u = 2'd0;
            3'b001, 3'b011: u = 2'd1;
            3'b100:         u = UNIT_MUL;
            default:        u = UNIT_BIT;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/nib_operand_pair.sv
module nib_operand_pair
    import nibble_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_a,
    input  logic          ld_b,
    input  nib_t          din_a,
    input  nib_t          din_b,
    output operand_pair_t ops
);
    nib_t a_q;
    nib_t b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (ld_a) a_q <= din_a;
            if (ld_b) b_q <= din_b;
        end
    end

    assign ops.a = a_q;
    assign ops.b = b_q;

    assert_hold_a_R8: assert property (@(posedge clk) disable iff (rst)
        !ld_a |=> $stable(a_q));
    assert_hold_b_R8: assert property (@(posedge clk) disable iff (rst)
        !ld_b |=> $stable(b_q));

endmodule

// File: rtl/nib_addsub.sv
module nib_addsub
    import nibble_alu_pkg::*;
(
    input  operand_pair_t ops,
    input  logic          sub_mode,
    output nib_t          sum
);
    nib_t b_eff;

    // Two's complement subtraction: A + ~B + 1; the carry out is dropped
    always_comb begin
        b_eff = sub_mode ? ~ops.b : ops.b;
        sum   = ops.a + b_eff + nib_t'(sub_mode);
    end

endmodule

// File: rtl/nib_mul.sv
module nib_mul
    import nibble_alu_pkg::*;
(
    input  operand_pair_t ops,
    input  logic          hi_sel,
    output nib_t          half
);
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = {{NIB_W{1'b0}}, ops.a} * {{NIB_W{1'b0}}, ops.b};
        half = hi_sel ? prod[PROD_W-1:NIB_W] : prod[NIB_W-1:0];
    end

endmodule

// File: rtl/nib_bitwise.sv
module nib_bitwise
    import nibble_alu_pkg::*;
(
    input  operand_pair_t ops,
    input  logic [1:0]    op_sel,
    output nib_t          res
);
    always_comb begin
        case (op_sel)
            LOGIC_AND: res = ops.a & ops.b;
            LOGIC_XOR: res = ops.a ^ ops.b;
            LOGIC_OR:  res = ops.a | ops.b;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/nibble_alu_cluster.sv
module nibble_alu_cluster
    import nibble_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic [3:0] bus_x,
    input  logic [3:0] bus_y,
    input  logic       mul_hi_sel,
    output logic [3:0] res_data,
    output logic       res_valid
);
    operand_pair_t ops   [N_UNITS];
    nib_t          add_r [N_ADD];
    nib_t          mul_r;
    nib_t          bit_r;
    nib_t          res_d;
    logic          is_load;
    logic          is_run;
    logic          res_valid_q;
    nib_t          res_data_q;

    assign is_load = cmd_valid && !cmd_code[3];
    assign is_run  = cmd_valid &&  cmd_code[3];

    // One operand pair per unit; code bits 2:1 address the unit
    for (genvar u = 0; u < N_UNITS; u++) begin : g_latch
        logic hit;
        assign hit = is_load && (cmd_code[2:1] == 2'(u));
        nib_operand_pair u_pair (
            .clk   (clk),
            .rst   (rst),
            .ld_a  (hit && !cmd_code[0]),
            .ld_b  (hit &&  cmd_code[0]),
            .din_a (bus_x),
            .din_b (bus_y),
            .ops   (ops[u])
        );
    end

    // Adders: code bit 1 distinguishes subtract (A/B) from add (8/9)
    for (genvar k = 0; k < N_ADD; k++) begin : g_add
        nib_addsub u_addsub (
            .ops      (ops[k]),
            .sub_mode (cmd_code[1]),
            .sum      (add_r[k])
        );
    end

    nib_mul u_mul (
        .ops    (ops[UNIT_MUL]),
        .hi_sel (mul_hi_sel),
        .half   (mul_r)
    );

    nib_bitwise u_bit (
        .ops    (ops[UNIT_BIT]),
        .op_sel (cmd_code[1:0]),
        .res    (bit_r)
    );

    always_comb begin
        case (run_target(cmd_code))
            2'd0:     res_d = add_r[0];
            2'd1:     res_d = add_r[1];
            UNIT_MUL: res_d = mul_r;
            default:  res_d = bit_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
        end else begin
            res_valid_q <= is_run;
            if (is_run) res_data_q <= res_d;
        end
    end

    assign res_valid = res_valid_q;
    assign res_data  = res_data_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == 4'h0));
    assert_no_pulse_on_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_code[3]) |=> !res_valid);
    assert_pulse_after_run_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code[3]) |=> res_valid);
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_code[3]) |=> (!res_valid && $stable(res_data)));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !res_valid);

endmodule

// File: tb/nibble_alu_cluster_tb.sv
module nibble_alu_cluster_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [3:0] cmd_code;
    logic [3:0] bus_x;
    logic [3:0] bus_y;
    logic       mul_hi_sel;
    logic [3:0] res_data;
    logic       res_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    nibble_alu_cluster dut_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .bus_x      (bus_x),
        .bus_y      (bus_y),
        .mul_hi_sel (mul_hi_sel),
        .res_data   (res_data),
        .res_valid  (res_valid)
    );

    // {run code, A, B, hi select, expected}
    localparam int NV = 13;
    localparam logic [16:0] VEC [NV] = '{
        {4'h8, 4'h3, 4'h4, 1'b0, 4'h7},   // R3
        {4'h8, 4'hF, 4'h2, 1'b0, 4'h1},   // R3 wrap
        {4'h9, 4'h9, 4'h9, 1'b0, 4'h2},   // R3 adder 1
        {4'hA, 4'h3, 4'h5, 1'b0, 4'hE},   // R4 3-5=-2
        {4'hB, 4'h7, 4'h8, 1'b0, 4'hF},   // R4 7-(-8) wraps
        {4'hA, 4'h0, 4'h1, 1'b0, 4'hF},   // R4 0-1=-1
        {4'hB, 4'h5, 4'h5, 1'b0, 4'h0},   // R4 zero
        {4'hC, 4'h3, 4'h5, 1'b0, 4'hF},   // R5 15 low
        {4'hC, 4'hF, 4'hF, 1'b1, 4'hE},   // R5 225 high
        {4'hC, 4'h6, 4'h7, 1'b0, 4'hA},   // R5 42 low
        {4'hD, 4'hC, 4'hA, 1'b0, 4'h8},   // R6 and
        {4'hE, 4'hC, 4'hA, 1'b0, 4'h6},   // R6 xor
        {4'hF, 4'hC, 4'hA, 1'b0, 4'hE}    // R6 or
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // One strobed command, returns at the falling edge after it is taken
    task automatic issue(input logic [3:0] code, input logic [3:0] x,
                         input logic [3:0] y, input logic hi);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_code   = code;
        bus_x      = x;
        bus_y      = y;
        mul_hi_sel = hi;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    // Unit of a run code per R2 numbering
    function automatic logic [1:0] unit_of(input logic [3:0] code);
        case (code)
            4'h8, 4'hA: return 2'd0;
            4'h9, 4'hB: return 2'd1;
            4'hC:       return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

    task automatic load_pair(input logic [1:0] u, input logic [3:0] a, input logic [3:0] b);
        issue({1'b0, u, 1'b0}, a, 4'h0, 1'b0);
        check("R2 no pulse on load A", {3'b0, res_valid}, 4'h0);
        issue({1'b0, u, 1'b1}, 4'h0, b, 1'b0);
        check("R2 no pulse on load B", {3'b0, res_valid}, 4'h0);
    endtask

    task automatic run_check(input string req, input logic [3:0] code,
                             input logic hi, input logic [3:0] exp);
        issue(code, 4'h0, 4'h0, hi);
        check({req, " valid"}, {3'b0, res_valid}, 4'h1);
        check({req, " data"}, res_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_code = 4'h0;
        bus_x = 4'h0; bus_y = 4'h0; mul_hi_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", {3'b0, res_valid}, 4'h0);
        check("R1 reset data", res_data, 4'h0);
        run_check("R1 adder after reset", 4'h9, 1'b0, 4'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0] code, a, b, exp;
            logic hi;
            {code, a, b, hi, exp} = VEC[i];
            load_pair(unit_of(code), a, b);
            run_check($sformatf("R3-6 vec%0d", i), code, hi, exp);
        end

        // R5: same operands, other half
        run_check("R5 low half of 42", 4'hC, 1'b0, 4'hA);
        run_check("R5 high half of 42", 4'hC, 1'b1, 4'h2);

        // R7: pulse width and hold
        @(negedge clk);
        check("R7 pulse one cycle", {3'b0, res_valid}, 4'h0);
        check("R7 data held", res_data, 4'h2);

        // R8: reuse and independence
        load_pair(2'd0, 4'h2, 4'h3);
        run_check("R8 first use", 4'h8, 1'b0, 4'h5);
        issue(4'h1, 4'h0, 4'h6, 1'b0);
        run_check("R8 A kept after B reload", 4'h8, 1'b0, 4'h8);
        run_check("R8 subtract reuse", 4'hA, 1'b0, 4'hC);
        load_pair(2'd1, 4'h1, 4'h1);
        issue(4'h0, 4'hF, 4'h0, 1'b0);
        run_check("R8 adder 1 untouched", 4'h9, 1'b0, 4'h2);

        // R9: unstrobed traffic ignored
        @(negedge clk);
        cmd_code = 4'h0; bus_x = 4'h9; bus_y = 4'h9;
        @(negedge clk);
        check("R9 no pulse on idle load", {3'b0, res_valid}, 4'h0);
        cmd_code = 4'h8;
        @(negedge clk);
        check("R9 no pulse on idle run", {3'b0, res_valid}, 4'h0);
        check("R9 data unchanged", res_data, 4'h2);
        run_check("R9 operand unchanged", 4'h8, 1'b0, 4'h5);

        // R1: mid-run reset clears operands
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid run data", res_data, 4'h0);
        run_check("R1 operands cleared", 4'hF, 1'b0, 4'h0);

        finish_run();
    end

endmodule